// File: doc/BRIEF.md
# Sequencer Interrupt Handshake Control Register

This block is one memory-mapped control word for a small sequencer core. Software uses it to raise a level-sensitive interrupt and to send that interrupt to a host processor, a power controller, both, or neither. The interrupt enable is sticky. Once it is set, a plain write cannot clear it. Only an accepted acknowledge clears it. The routing selection is frozen while the interrupt is pending, so the set of destinations cannot change under an open request.

The same word carries three plain configuration bits: run enable, software control and bus-error detection enable. It also carries two command bits that clear themselves, one for a soft reset of the sequencer and one for clearing its loop counter. Each command bit appears on an output as a single-cycle pulse. Access is through a write strobe, a byte address, write data and combinational read data. A read returns the live stored fields, and the command bits read as 1 only during their pulse cycle. The asynchronous active-low reset is asserted at once and released in step with the clock.

Top module: `seqirq_ctrl_reg`

## Requirements
- R1: After reset, every field is 0, both interrupt outputs and both pulse outputs are low, and a read of the register returns 0.
- R2: Routing field bits 7:6 select the destinations: 0 means none, 1 means host only, 2 means power controller only, 3 means both. A selected output is high exactly while the enable (bit 5) is set.
- R3: While the enable is clear, a write loads bit 5 into it. Once the enable is set, a write with bit 5 at 0 leaves it set.
- R4: A write with the acknowledge (bit 8) at 1 while the enable is clear is discarded: the acknowledge still reads 0 and no other field is affected by it.
- R5: A write with bit 8 at 1 while the enable is set makes the acknowledge read 1 in the following cycle. In the cycle after that, the enable and the acknowledge both read 0 and both interrupt outputs are low.
- R6: While the enable is set, which includes the cycle with the acknowledge pending, writes leave the routing field unchanged. While the enable is clear, writes load it.
- R7: A write with bit 3 (soft reset) or bit 4 (loop clear) at 1 drives the matching pulse output high for exactly the next cycle. The bit reads 1 only in that cycle.
- R8: Bits 0 (run enable), 1 (software control) and 2 (bus-error detect enable) load on every write, read back, and drive their outputs.
- R9: A write to any other address changes nothing, and a read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the current address |
| host_irq | output | 1 | Interrupt request to the host processor |
| pwr_irq | output | 1 | Interrupt request to the power controller |
| soft_rst_pulse | output | 1 | Single-cycle soft reset command |
| loop_clr_pulse | output | 1 | Single-cycle loop counter clear command |
| run_en | output | 1 | Run enable configuration bit |
| sw_ctrl | output | 1 | Software control configuration bit |
| buserr_det_en | output | 1 | Bus-error detection enable bit |

## Verification
Two things can coincide in one cycle: a write that tries to reload the routing field and the enable, and the acknowledge or pending interrupt that decides whether that write takes effect. The bench provokes this in two ways. In one, a single word sets the enable and a new routing value together while the enable is clear. In the other, a word carries the acknowledge, a different routing value and the enable bit at 0 while the interrupt is open. The bench then judges the routing and enable read back in the cycle that follows and in the cycle after it. Random writes with a biased acknowledge bit also land such words during the acknowledge-pending cycle. The bench checks these against a cycle model that keeps the old routing until the enable has dropped.

// File: rtl/seqirq_pkg.sv
package seqirq_pkg;
  // Field positions inside the control word; a neighbour decodes them.
  localparam int unsigned BIT_RUN     = 0;
  localparam int unsigned BIT_SWCTL   = 1;
  localparam int unsigned BIT_BERR    = 2;
  localparam int unsigned BIT_SRST    = 3;
  localparam int unsigned BIT_LCLR    = 4;
  localparam int unsigned BIT_IRQEN   = 5;
  localparam int unsigned BIT_ROUTE_L = 6;
  localparam int unsigned BIT_ROUTE_H = 7;
  localparam int unsigned BIT_ACK     = 8;
  localparam int unsigned FIELD_TOP   = 8;

  localparam int unsigned NUM_CFG     = 3;
  localparam int unsigned NUM_STROBE  = 2;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_HOST = 2'd1,
    ROUTE_PWR  = 2'd2,
    ROUTE_BOTH = 2'd3
  } route_t;
endpackage

// File: rtl/seqirq_rst_sync.sv
module seqirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seqirq_cfg_bits.sv
module seqirq_cfg_bits #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_d[i] = q[i];
      if (load) q_d[i] = din[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_d[i];
    end
  end
endmodule

// File: rtl/seqirq_strobe.sv
module seqirq_strobe #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [N-1:0] cmd,
  output logic [N-1:0] pulse
);
  logic [N-1:0] pulse_d;

  for (genvar i = 0; i < N; i++) begin : g_cmd
    // A command bit lives for exactly one cycle after it is written.
    always_comb begin
      pulse_d[i] = hit & cmd[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= pulse_d[i];
    end
  end
endmodule

// File: rtl/seqirq_handshake.sv
module seqirq_handshake
  import seqirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  logic   wr_en_bit,
  input  logic   wr_ack_bit,
  input  route_t wr_route,
  output logic   irq_en,
  output logic   ack_pend,
  output route_t route
);
  logic   en_d;
  logic   ack_d;
  route_t route_d;

  always_comb begin
    en_d  = irq_en;
    ack_d = 1'b0;
    if (ack_pend) begin
      // Enable and acknowledge fall together.
      en_d  = 1'b0;
      ack_d = 1'b0;
    end else if (irq_en) begin
      ack_d = hit & wr_ack_bit;
    end else if (hit) begin
      en_d = wr_en_bit;
    end
  end

  always_comb begin
    route_d = route;
    if (hit && !irq_en) route_d = wr_route;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      ack_pend <= 1'b0;
      route    <= ROUTE_NONE;
    end else begin
      irq_en   <= en_d;
      ack_pend <= ack_d;
      route    <= route_d;
    end
  end
endmodule

// File: rtl/seqirq_ctrl_reg.sv
module seqirq_ctrl_reg
  import seqirq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter logic [7:0]  CTRL_ADDR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              host_irq,
  output logic              pwr_irq,
  output logic              soft_rst_pulse,
  output logic              loop_clr_pulse,
  output logic              run_en,
  output logic              sw_ctrl,
  output logic              buserr_det_en
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_ADDR);

  logic                  rst_n_sync;
  logic                  addr_hit;
  logic                  wr_hit;
  logic [NUM_CFG-1:0]    cfg_q;
  logic [NUM_STROBE-1:0] strobe_q;
  logic                  irq_en;
  logic                  ack_pend;
  route_t                route;
  logic [FIELD_TOP:0]    word;

  seqirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign addr_hit = (addr == MY_ADDR);
  assign wr_hit   = wr_en & addr_hit;

  seqirq_cfg_bits #(.N(NUM_CFG)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (wr_hit),
    .din   (wdata[BIT_BERR:BIT_RUN]),
    .q     (cfg_q)
  );

  seqirq_strobe #(.N(NUM_STROBE)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .hit   (wr_hit),
    .cmd   (wdata[BIT_LCLR:BIT_SRST]),
    .pulse (strobe_q)
  );

  seqirq_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .hit        (wr_hit),
    .wr_en_bit  (wdata[BIT_IRQEN]),
    .wr_ack_bit (wdata[BIT_ACK]),
    .wr_route   (route_t'(wdata[BIT_ROUTE_H:BIT_ROUTE_L])),
    .irq_en     (irq_en),
    .ack_pend   (ack_pend),
    .route      (route)
  );

  assign run_en         = cfg_q[0];
  assign sw_ctrl        = cfg_q[1];
  assign buserr_det_en  = cfg_q[2];
  assign soft_rst_pulse = strobe_q[0];
  assign loop_clr_pulse = strobe_q[1];

  assign host_irq = irq_en & route[0];
  assign pwr_irq  = irq_en & route[1];

  always_comb begin
    word = {ack_pend, route, irq_en, strobe_q, cfg_q};
    rdata = '0;
    if (addr_hit) rdata[FIELD_TOP:0] = word;
  end
endmodule

// File: rtl/seqirq_ctrl_reg_chk.sv
module seqirq_ctrl_reg_chk
  import seqirq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_en,
  input logic              ack_pend,
  input logic [1:0]        route,
  input logic              host_irq,
  input logic              pwr_irq,
  input logic              soft_rst_pulse
);
  assert_ack_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[BIT_ACK] && !irq_en && !ack_pend) |=> !ack_pend);

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !ack_pend) |=> irq_en);

  assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pend |=> (!irq_en && !ack_pend && !host_irq && !pwr_irq));

  assert_route_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> $stable(route));

  assert_srst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $past(wr_hit && wdata[BIT_SRST]));

  assert_no_req_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(!irq_en));
endmodule

bind seqirq_ctrl_reg seqirq_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_sync),
  .wr_hit         (wr_hit),
  .wdata          (wdata),
  .irq_en         (irq_en),
  .ack_pend       (ack_pend),
  .route          (route),
  .host_irq       (host_irq),
  .pwr_irq        (pwr_irq),
  .soft_rst_pulse (soft_rst_pulse)
);

// File: tb/seqirq_ctrl_reg_test.sv
module seqirq_ctrl_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [7:0] CA = 8'h00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic host_irq, pwr_irq, soft_rst_pulse, loop_clr_pulse, run_en, sw_ctrl, buserr_det_en;

  int tests = 0;
  int fails = 0;

  // bench model
  logic       m_en, m_ack, m_sr, m_lc;
  logic [1:0] m_route;
  logic [2:0] m_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqirq_ctrl_reg #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CA)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .host_irq(host_irq), .pwr_irq(pwr_irq),
    .soft_rst_pulse(soft_rst_pulse), .loop_clr_pulse(loop_clr_pulse),
    .run_en(run_en), .sw_ctrl(sw_ctrl), .buserr_det_en(buserr_det_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [AW-1:0] a);
    logic [31:0] v;
    v = '0;
    if (a == CA) v[8:0] = {m_ack, m_route, m_en, m_lc, m_sr, m_cfg};
    return v;
  endfunction

  function automatic logic [1:0] exp_irq();
    return {m_en & m_route[1], m_en & m_route[0]};
  endfunction

  task automatic model_reset();
    m_en = 0; m_ack = 0; m_sr = 0; m_lc = 0; m_route = 0; m_cfg = 0;
  endtask

  task automatic model_edge(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    logic hit, n_en, n_ack;
    hit = w && (a == CA);
    n_en = m_en; n_ack = 0;
    if (m_ack) begin n_en = 0; n_ack = 0; end
    else if (m_en) n_ack = hit & d[8];
    else if (hit) n_en = d[5];
    if (hit && !m_en) m_route = d[7:6];
    if (hit) m_cfg = d[2:0];
    m_sr = hit & d[3];
    m_lc = hit & d[4];
    m_en = n_en; m_ack = n_ack;
  endtask

  // full comparison of every output
  task automatic check_all(input string tag);
    chk(rdata == exp_rdata(addr), {tag, " rdata"}, rdata, exp_rdata(addr));
    chk({pwr_irq, host_irq} == exp_irq(), {tag, " R2 irq"}, {30'd0, pwr_irq, host_irq}, {30'd0, exp_irq()});
    chk({loop_clr_pulse, soft_rst_pulse} == {m_lc, m_sr}, {tag, " R7 pulse"},
        {30'd0, loop_clr_pulse, soft_rst_pulse}, {30'd0, m_lc, m_sr});
    chk({buserr_det_en, sw_ctrl, run_en} == m_cfg, {tag, " R8 cfg"},
        {29'd0, buserr_det_en, sw_ctrl, run_en}, {29'd0, m_cfg});
  endtask

  // one cycle: drive at negedge, model at posedge, sample at next negedge
  task automatic step(input logic w, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge(w, a, d);
    @(negedge clk);
    wr_en = 0;
    check_all(tag);
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(1'b1, CA, d, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, CA, 32'd0, tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // R8 plain bits, R7 strobes
    wr(32'h0000_0005, "R8 load cfg");
    wr(32'h0000_0018, "R7 both strobes");
    idle("R7 strobe self-clear");

    // R4 ack while enable clear is discarded
    wr(32'h0000_0100, "R4 ack discarded");
    chk(rdata[8] == 1'b0, "R4 ack bit", {31'd0, rdata[8]}, 32'd0);

    // R6/R3 same-word set of enable and route while clear; host only
    wr(32'h0000_0060, "R6 set en+route host");
    chk(host_irq && !pwr_irq, "R2 host only", {30'd0, pwr_irq, host_irq}, 32'd1);
    // R3 write of 0 to enable keeps it; R6 route write ignored
    wr(32'h0000_00C0, "R3 en sticky");
    chk(rdata[5] == 1'b1, "R3 enable held", {31'd0, rdata[5]}, 32'd1);
    chk(rdata[7:6] == 2'd1, "R6 route frozen", {30'd0, rdata[7:6]}, 32'd1);

    // R5 ack with new route in same word
    wr(32'h0000_0180, "R5 ack accepted");
    chk(rdata[8] && rdata[5], "R5 ack pending", {23'd0, rdata[8:0]}, 32'h160);
    wr(32'h0000_00E0, "R6 write in ack cycle");
    chk(rdata[8:5] == 4'b0010 && !host_irq, "R5 en and ack dropped", {23'd0, rdata[8:0]}, 32'h40);

    // R2 each routing code
    for (int r = 0; r < 4; r++) begin
      wr({24'd0, r[1:0], 6'b100000}, "R2 route code");
      wr(32'h0000_0100, "R5 ack");
      idle("R5 drop");
    end
    wr(32'h0000_0000, "R2 route none");
    wr(32'h0000_0020, "R2 none en");
    chk(!host_irq && !pwr_irq, "R2 none both low", {30'd0, pwr_irq, host_irq}, 32'd0);
    wr(32'h0000_0100, "R5 ack");
    idle("R5 drop");

    // R9 other address
    step(1'b1, 8'h04, 32'h0000_01FF, "R9 foreign write");
    chk(rdata == 32'd0, "R9 foreign read", rdata, 32'd0);
    idle("R9 unchanged");

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [AW-1:0] a;
      d = $urandom();
      if (($urandom() % 3) == 0) d[8] = 1'b1;
      a = (($urandom() % 6) == 0) ? AW'($urandom()) : CA;
      step(($urandom() % 4) != 0, a, d, "R3 R5 R6 random");
    end

    finish_run();
  end
endmodule